// File: doc/BRIEF.md
# Scheduled Converter Sync Pulse Generator

This block raises a synchronisation pulse toward a local data converter at one exact count of a free-running cycle counter. A remote timing master chooses the instant and gives the same value to every unit. That value is in the master's count space. Each unit converts it to its own count space by subtracting the offset it holds between the two counters. The block only reads the counter and compares against it. Loading a target never stops, reloads or otherwise disturbs the count.

The converter and the counter run from one oscillator. As a result, once the pulse has started the conversion, the two stay aligned. A target that is already reached or passed when it is loaded is flagged as late and never fires. Each good load produces exactly one pulse. The pulse width is a parameter.

Top module: `sync_pulse_sched`

## Requirements
- R1: After reset, `syncOut`, `armed`, `fired` and `lateErr` are all low, and no pulse appears until a target is loaded.
- R2: The local target is `targetIn - offset` modulo 2^CNT_W. `syncOut` goes high in the cycle right after the clock edge at which `cycleCount` equals the local target while armed.
- R3: Every pulse stays high for exactly PULSE_LEN consecutive cycles (default 4), then drops.
- R4: A load whose target is in the future sets `armed` high and `fired` and `lateErr` low on the next cycle. Firing clears `armed` and sets `fired`, which stays high until the next load.
- R5: A load where the CNT_W-bit two's complement value (local target − `cycleCount`) is zero or negative sets `lateErr` and clears `armed`. This also cancels any earlier arming, and no pulse follows.
- R6: A pulse fires once per arming. If the counter later shows the same target value again, nothing fires.
- R7: A target that lies beyond the counter's wrap from all ones to zero is treated as future and fires at the correct count.
- R8: A load while armed replaces the previous target. The old target no longer fires.
- R9: A load in the same cycle as a match takes priority. The old target does not fire, and the new one is armed.
- R10: A good load after a late one clears `lateErr`.
- R11: A load during a pulse does not shorten that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the counter and converter |
| rstN | input | 1 | Active-low synchronous reset |
| cycleCount | input | CNT_W | Free-running local cycle counter value |
| offset | input | CNT_W | Master count minus local count |
| targetIn | input | CNT_W | Firing instant in master count space |
| loadStrobe | input | 1 | One-cycle strobe that loads `targetIn` |
| syncOut | output | 1 | Sync pulse to the converter |
| armed | output | 1 | A future target is pending |
| fired | output | 1 | The pending target has fired |
| lateErr | output | 1 | The last loaded target was not in the future |

## Verification
The bench arms targets with a plain positive offset, with an offset that is negative as two's complement, and across the counter wrap. These three cases separate a correct modular subtraction from a magnitude comparison or from the wrong operand order. Loads at a lead of zero and of a negative value check the late boundary against a lead of one. Replacement loads, including a load on the match cycle, show whether the stored target is updated or the old match still fires. Moving the counter back over a target that has already fired, and loading in the middle of a pulse, separate single-shot firing and a fixed width from retriggering or truncation.

// File: rtl/sync_pulse_pkg.sv
package sync_pulse_pkg;

  typedef struct packed {
    logic captureTarget;
    logic startPulse;
  } dpCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FIRED = 2'd2,
    ST_LATE  = 2'd3
  } schedState_t;

endpackage

// File: rtl/sync_pulse_dp.sv
module sync_pulse_dp
  import sync_pulse_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cycleCount,
  input  logic [CNT_W-1:0] offset,
  input  logic [CNT_W-1:0] targetIn,
  input  dpCtl_t           ctl,
  output logic             targetLate,
  output logic             targetHit,
  output logic             syncOut
);

  localparam int LEN_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam int RUN_W = LEN_W + 2;

  logic [CNT_W-1:0] pendingLocal;
  logic [CNT_W-1:0] leadCycles;
  logic [CNT_W-1:0] targetReg;

  // Master-space target moved into local space, modulo the counter width
  assign pendingLocal = targetIn - offset;
  assign leadCycles   = pendingLocal - cycleCount;
  assign targetLate   = leadCycles[CNT_W-1] || (leadCycles == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetReg <= '0;
    end else if (ctl.captureTarget) begin
      targetReg <= pendingLocal;
    end
  end

  assign targetHit = (cycleCount == targetReg);

  generate
    if (PULSE_LEN == 1) begin : g_single
      logic pulseReg;
      always_ff @(posedge clk) begin
        if (!rstN) pulseReg <= 1'b0;
        else       pulseReg <= ctl.startPulse;
      end
      assign syncOut = pulseReg;
    end else begin : g_multi
      logic             pulseReg;
      logic [LEN_W-1:0] remain;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          pulseReg <= 1'b0;
          remain   <= '0;
        end else if (ctl.startPulse) begin
          pulseReg <= 1'b1;
          remain   <= LEN_W'(PULSE_LEN - 1);
        end else if (pulseReg) begin
          if (remain == '0) pulseReg <= 1'b0;
          else              remain   <= remain - 1'b1;
        end
      end
      assign syncOut = pulseReg;
    end
  endgenerate

  // Checker: cycles since the last pulse start, saturating
  logic [RUN_W-1:0] sinceStart;
  always_ff @(posedge clk) begin
    if (!rstN) sinceStart <= '1;
    else if (ctl.startPulse) sinceStart <= RUN_W'(1);
    else if (sinceStart != '1) sinceStart <= sinceStart + 1'b1;
  end

  p_start_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startPulse |=> syncOut);

  p_width_exact_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncOut) |-> (sinceStart == RUN_W'(PULSE_LEN + 1)));

  p_fire_on_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startPulse |-> (cycleCount == targetReg));

endmodule

// File: rtl/sync_pulse_ctrl.sv
module sync_pulse_ctrl
  import sync_pulse_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   loadStrobe,
  input  logic   targetLate,
  input  logic   targetHit,
  output dpCtl_t ctl,
  output logic   armed,
  output logic   fired,
  output logic   lateErr
);

  schedState_t state, stateNext;

  always_comb begin
    stateNext         = state;
    ctl.captureTarget = 1'b0;
    ctl.startPulse    = 1'b0;
    if (loadStrobe) begin
      // a new load always wins over a match of the old target
      if (targetLate) begin
        stateNext = ST_LATE;
      end else begin
        stateNext         = ST_ARMED;
        ctl.captureTarget = 1'b1;
      end
    end else if (state == ST_ARMED && targetHit) begin
      stateNext      = ST_FIRED;
      ctl.startPulse = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign armed   = (state == ST_ARMED);
  assign fired   = (state == ST_FIRED);
  assign lateErr = (state == ST_LATE);

  p_late_blocks_r5: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && targetLate) |=> (lateErr && !armed && !fired));

  p_match_fires_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && targetHit && !loadStrobe) |=> (fired && !armed));

  p_once_per_arm_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startPulse |-> armed);

  p_load_priority_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> !fired);

  p_status_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({armed, fired, lateErr}));

endmodule

// File: rtl/sync_pulse_sched.sv
module sync_pulse_sched
  import sync_pulse_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PULSE_LEN = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cycleCount,
  input  logic [CNT_W-1:0] offset,
  input  logic [CNT_W-1:0] targetIn,
  input  logic             loadStrobe,
  output logic             syncOut,
  output logic             armed,
  output logic             fired,
  output logic             lateErr
);

  dpCtl_t ctl;
  logic   targetLate;
  logic   targetHit;

  sync_pulse_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadStrobe (loadStrobe),
    .targetLate (targetLate),
    .targetHit  (targetHit),
    .ctl        (ctl),
    .armed      (armed),
    .fired      (fired),
    .lateErr    (lateErr)
  );

  sync_pulse_dp #(
    .CNT_W     (CNT_W),
    .PULSE_LEN (PULSE_LEN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cycleCount (cycleCount),
    .offset     (offset),
    .targetIn   (targetIn),
    .ctl        (ctl),
    .targetLate (targetLate),
    .targetHit  (targetHit),
    .syncOut    (syncOut)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!syncOut && !armed && !fired && !lateErr));

endmodule

// File: tb/tb_sync_pulse_sched.sv
`timescale 1ns/1ps
module tb_sync_pulse_sched;
  localparam int W   = 32;
  localparam int LEN = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] cnt = '0;
  logic [W-1:0] offset = '0;
  logic [W-1:0] targetIn = '0;
  logic         loadStrobe = 1'b0;
  logic         syncOut, armed, fired, lateErr;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  bit done = 0;

  logic [W-1:0] expQ[$];
  logic [W-1:0] cntAtEdge = '0;
  logic         prevSync = 1'b0;
  int           hiLen = 0;

  always #5 clk = ~clk;

  sync_pulse_sched #(.CNT_W(W), .PULSE_LEN(LEN)) dut (
    .clk(clk), .rstN(rstN), .cycleCount(cnt), .offset(offset),
    .targetIn(targetIn), .loadStrobe(loadStrobe),
    .syncOut(syncOut), .armed(armed), .fired(fired), .lateErr(lateErr)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cntAtEdge <= cnt;

  // Monitor: pops the expected firing count at each pulse start
  always @(negedge clk) begin
    if (rstN) begin
      if (syncOut && !prevSync) begin
        pulses++;
        hiLen = 1;
        if (expQ.size() == 0) begin
          check(1'b0, "R2/R6 unexpected pulse", 64'(cntAtEdge), 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
          logic [W-1:0] e;
          e = expQ.pop_front();
          check(cntAtEdge == e, "R2 fire count", 64'(cntAtEdge), 64'(e));
        end
      end else if (syncOut) begin
        hiLen++;
      end
      if (!syncOut && prevSync)
        check(hiLen == LEN, "R3 pulse width", 64'(hiLen), 64'(LEN));
    end
    prevSync = syncOut;
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt = cnt + 1'b1;
      loadStrobe = 1'b0;
    end
  endtask

  // Driver: loads a local-space target, predicts late/fire, checks status
  task automatic doLoad(input logic [W-1:0] localT, input string req);
    logic [W-1:0] lead;
    bit late;
    @(negedge clk);
    cnt = cnt + 1'b1;
    targetIn = localT + offset;
    loadStrobe = 1'b1;
    lead = localT - cnt;
    late = lead[W-1] || (lead == '0);
    if (!late) expQ.push_back(localT);
    @(negedge clk);
    cnt = cnt + 1'b1;
    loadStrobe = 1'b0;
    check(armed == !late && lateErr == late && !fired, req,
          64'({armed, lateErr, fired}), 64'({!late, late, 1'b0}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cnt = 32'd1000;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({syncOut, armed, fired, lateErr} == 4'b0, "R1 reset outputs",
          64'({syncOut, armed, fired, lateErr}), 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    step(3);
    check({syncOut, armed, fired, lateErr} == 4'b0 && pulses == 0, "R1 idle after reset",
          64'({syncOut, armed, fired, lateErr}), 64'd0);

    // R2/R4: plain positive offset
    offset = 32'd100;
    doLoad(cnt + 32'd40, "R4 armed after good load");
    step(50);
    check(fired && !armed && pulses == 1, "R4 fired after pulse",
          64'({fired, armed}), 64'b10);

    // R2: negative offset in two's complement
    offset = 32'hFFFF_FFF0;
    doLoad(cnt + 32'd12, "R2 armed with negative offset");
    step(25);
    check(pulses == 2, "R2 negative offset fired", 64'(pulses), 64'd2);

    // R7: target across the counter wrap
    offset = 32'd7;
    cnt = 32'hFFFF_FFF0;
    doLoad(32'd5, "R7 armed across wrap");
    step(30);
    check(pulses == 3 && fired, "R7 wrap target fired", 64'(pulses), 64'd3);

    // R5: zero lead, negative lead, then lead of one
    doLoad(cnt + 32'd1, "R5 zero lead is late");
    step(10);
    doLoad(cnt - 32'd4, "R5 past target is late");
    step(10);
    check(pulses == 3 && lateErr, "R5 no pulse from late loads", 64'(pulses), 64'd3);
    // R10: good load clears late, lead of one fires
    doLoad(cnt + 32'd2, "R10 good load clears late");
    step(10);
    check(pulses == 4, "R10 lead of one fires", 64'(pulses), 64'd4);

    // R5: late load cancels an earlier arming
    doLoad(cnt + 32'd30, "R5 arm before cancel");
    void'(expQ.pop_back());
    doLoad(cnt, "R5 late load cancels arm");
    step(40);
    check(pulses == 4 && lateErr, "R5 cancelled target silent", 64'(pulses), 64'd4);

    // R8: reload replaces target
    begin
      logic [W-1:0] oldT;
      oldT = cnt + 32'd50;
      doLoad(oldT, "R8 first arm");
      void'(expQ.pop_back());
      step(5);
      doLoad(cnt + 32'd15, "R8 replacement arm");
      step(70);
      check(pulses == 5, "R8 old target did not fire", 64'(pulses), 64'd5);
    end

    // R6: counter revisits a fired target
    begin
      logic [W-1:0] t6;
      t6 = cnt + 32'd10;
      doLoad(t6, "R6 arm");
      step(15);
      cnt = t6 - 32'd3;
      step(10);
      check(pulses == 6 && fired, "R6 single fire per arm", 64'(pulses), 64'd6);
    end

    // R9: load on the match cycle wins
    begin
      logic [W-1:0] t9;
      t9 = cnt + 32'd1 + 32'd8;
      doLoad(t9, "R9 first arm");
      void'(expQ.pop_back());
      while (cnt != t9 - 32'd1) step(1);
      @(negedge clk);
      cnt = cnt + 1'b1;
      targetIn = t9 + 32'd10 + offset;
      loadStrobe = 1'b1;
      expQ.push_back(t9 + 32'd10);
      step(1);
      check(armed && !syncOut && pulses == 6, "R9 load beats match",
            64'({armed, syncOut}), 64'b10);
      step(20);
      check(pulses == 7, "R9 new target fired", 64'(pulses), 64'd7);
    end

    // R11: load during pulse keeps width
    doLoad(cnt + 32'd3, "R11 arm");
    while (!syncOut) step(1);
    doLoad(cnt + 32'd20, "R11 load mid pulse");
    step(30);
    check(pulses == 9, "R11 both pulses seen", 64'(pulses), 64'd9);

    check(expQ.size() == 0, "R2 no missing pulse", 64'(expQ.size()), 64'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule